// File: doc/BRIEF.md
# Bearer-Channel Receive Buffer with Threshold Interrupts

This block buffers the received bytes of one 64 kbit/s bearer channel for a host processor. Bytes arrive one at a time from an upstream deframer or line sampler. They go into a 64-byte ring. Fixed-size blocks of data are handed to the host by interrupt. The block size is set by a shared threshold input: 32 or 48 bytes. When a block of that size has filled, `irq_rmr` pulses. In framed mode a byte flagged as the last of a message also closes the current block, whatever its size, and `irq_rme` pulses instead. The length of the delivered block is reported on `blk_len`.

The host drains the delivered block through a single read port. `host_rdata` always shows the next unread byte, and a one-cycle `host_rd` pulse steps to the following byte. The space stays held until the host issues a receive-acknowledge pulse on `host_rack`. Up to two closed blocks can exist at once: one is offered to the host and one waits behind it. Its interrupt is raised when the first block is acknowledged.

If the host is late and a byte finds no room, the byte is discarded. The block then pulses `irq_ovf` and sets a sticky overflow flag, which stays set until the host reads status. In transparent mode the end-of-message flag is ignored, bytes are stored unchanged, and only threshold interrupts occur.

Top module: `rxq_ctl`

## Requirements
- R1: After reset, `irq_rmr`, `irq_rme`, `irq_ovf` and `stat_ovf` are 0 and `blk_len` is 0.
- R2: The block size is 32 bytes when `cfg_thr48` is 0 and 48 bytes when it is 1. A block one byte short of that size raises no interrupt.
- R3: `irq_rmr` is high for exactly one cycle, in the cycle after the clock edge that stored the byte completing a full-size block. `blk_len` then shows the block size.
- R4: In framed mode (`cfg_xp`=0), a stored byte with `rx_eom`=1 closes the current block. `irq_rme` then pulses in the following cycle, and `blk_len` gives the byte count of that block.
- R5: `host_rdata` shows the bytes of the offered block in arrival order, and each `host_rd` pulse advances by one byte. Once all bytes of the block have been read, a further `host_rd` does not advance.
- R6: A `host_rack` pulse frees the offered block. If a closed block was waiting, it is offered next, and its interrupt pulses in the cycle after the acknowledge edge.
- R7: The ring holds 64 bytes. A byte is discarded if the ring is full, or if the byte would close a block while two blocks are already closed. For each discarded byte, `irq_ovf` pulses for one cycle and `stat_ovf` is set. Discarded bytes never appear on `host_rdata`.
- R8: `stat_ovf` stays set until a `host_stat_rd` pulse clears it, unless a byte is discarded in that same cycle.
- R9: In transparent mode (`cfg_xp`=1), `rx_eom` has no effect. Bytes are stored unchanged, only full-size blocks are delivered, and `irq_rme` never pulses.
- R10: A `host_rack` pulse while no block is offered has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_thr48 | input | 1 | Block size select: 0 gives 32 bytes, 1 gives 48 bytes |
| cfg_xp | input | 1 | 1 selects transparent mode, 0 selects framed mode |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_eom | input | 1 | Marks the byte as the last of a message (framed mode only) |
| host_rd | input | 1 | Advance to the next byte of the offered block |
| host_rdata | output | 8 | Next unread byte of the offered block |
| host_rack | input | 1 | Receive-acknowledge: release the offered block |
| host_stat_rd | input | 1 | Status read; clears the overflow flag |
| irq_rmr | output | 1 | One-cycle pulse: a full-size block is offered |
| irq_rme | output | 1 | One-cycle pulse: a message-ending block is offered |
| irq_ovf | output | 1 | One-cycle pulse: a byte was discarded |
| stat_ovf | output | 1 | Sticky overflow flag |
| blk_len | output | 7 | Byte count of the most recently offered block |

## Verification
The bench sends blocks one byte short of the threshold for both sizes, to catch an off-by-one that would raise the interrupt early or late. It closes two short framed messages back to back. This makes the second one wait, and shows that a design which drops or loses the waiting block never raises its interrupt after the acknowledge. It leaves an acknowledge late so that a byte arrives into a full ring. A design that stored that byte would show it on the read port, and one that did not flag it would leave `stat_ovf` low. It also reads past the end of a block, and streams in transparent mode with end flags set, where any `irq_rme` or shortened block is an error.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Block size chosen by the shared threshold select.
  function automatic int unsigned thr_bytes(input logic hi_sel,
                                            input int unsigned lo_v,
                                            input int unsigned hi_v);
    return hi_sel ? hi_v : lo_v;
  endfunction

  // A block closes when it reaches the threshold or the message ends.
  function automatic logic closes_block(input int unsigned fill_after,
                                        input int unsigned thr,
                                        input logic msg_end);
    return (fill_after >= thr) || msg_end;
  endfunction

  // Ring pointer arithmetic; the depth is a power of two, so wrap is truncation.
  function automatic int unsigned ring_add(input int unsigned ptr,
                                           input int unsigned step,
                                           input int unsigned depth);
    return (ptr + step) % depth;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/rxq_admit.sv
module rxq_admit #(
  parameter int DEPTH  = 64,
  parameter int THR_LO = 32,
  parameter int THR_HI = 48,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_thr48,
  input  logic          cfg_xp,
  input  logic          rx_valid,
  input  logic          rx_eom,
  input  logic          slots_full,
  input  logic          rel_vld,
  input  logic [CW-1:0] rel_len,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          seal,
  output logic          seal_eom,
  output logic [CW-1:0] seal_len,
  output logic          drop
);

  logic [CW-1:0] used, used_nx;
  logic [CW-1:0] fill, fill_inc, thr_n;
  logic [AW-1:0] wptr;
  logic          msg_end, closes, room, accept;

  assign thr_n    = CW'(rxq_pkg::thr_bytes(cfg_thr48, THR_LO, THR_HI));
  assign fill_inc = fill + CW'(1);
  assign msg_end  = rx_eom && !cfg_xp;
  assign closes   = rxq_pkg::closes_block(int'(fill_inc), int'(thr_n), msg_end);
  assign room     = used < CW'(DEPTH);
  assign accept   = rx_valid && room && !(closes && slots_full);
  assign drop     = rx_valid && !accept;

  assign wr_en    = accept;
  assign wr_addr  = wptr;
  assign seal     = accept && closes;
  assign seal_eom = msg_end;
  assign seal_len = fill_inc;

  always_comb begin
    used_nx = used;
    if (accept)  used_nx = used_nx + CW'(1);
    if (rel_vld) used_nx = used_nx - rel_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used <= '0;
      fill <= '0;
      wptr <= '0;
    end else begin
      used <= used_nx;
      if (accept) begin
        wptr <= AW'(rxq_pkg::ring_add(int'(wptr), 1, DEPTH));
        fill <= closes ? '0 : fill_inc;
      end
    end
  end

  // R7
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used <= CW'(DEPTH));

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && used == CW'(DEPTH)) |-> drop);

endmodule

// File: rtl/rxq_slots.sv
module rxq_slots #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seal,
  input  logic          seal_eom,
  input  logic [CW-1:0] seal_len,
  input  logic          drop,
  input  logic          host_rd,
  input  logic          host_rack,
  input  logic          host_stat_rd,
  output logic          slots_full,
  output logic          rel_vld,
  output logic [CW-1:0] rel_len,
  output logic [AW-1:0] rd_addr,
  output logic          irq_rmr,
  output logic          irq_rme,
  output logic          irq_ovf,
  output logic          stat_ovf,
  output logic [CW-1:0] blk_len
);

  // offered block (p_*) and waiting block (q_*)
  logic          p_vld, p_eom, q_vld, q_eom;
  logic [CW-1:0] p_len, q_len;
  logic          np_vld, np_eom, nq_vld, nq_eom;
  logic [CW-1:0] np_len, nq_len;
  logic          present;
  logic [AW-1:0] base;
  logic [CW-1:0] off;
  logic          rd_step;

  assign rel_vld    = host_rack && p_vld;
  assign rel_len    = p_len;
  assign slots_full = p_vld && q_vld;
  assign rd_addr    = AW'(rxq_pkg::ring_add(int'(base), int'(off), DEPTH));
  assign rd_step    = host_rd && p_vld && (off < p_len);

  always_comb begin
    np_vld = p_vld; np_eom = p_eom; np_len = p_len;
    nq_vld = q_vld; nq_eom = q_eom; nq_len = q_len;
    present = 1'b0;
    if (rel_vld) begin
      np_vld = q_vld; np_eom = q_eom; np_len = q_len;
      nq_vld = 1'b0;
      present = q_vld;
    end
    if (seal) begin
      if (!np_vld) begin
        np_vld = 1'b1; np_eom = seal_eom; np_len = seal_len;
        present = 1'b1;
      end else begin
        nq_vld = 1'b1; nq_eom = seal_eom; nq_len = seal_len;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_vld <= 1'b0; p_eom <= 1'b0; p_len <= '0;
      q_vld <= 1'b0; q_eom <= 1'b0; q_len <= '0;
      base <= '0; off <= '0;
      irq_rmr <= 1'b0; irq_rme <= 1'b0; irq_ovf <= 1'b0;
      stat_ovf <= 1'b0; blk_len <= '0;
    end else begin
      p_vld <= np_vld; p_eom <= np_eom; p_len <= np_len;
      q_vld <= nq_vld; q_eom <= nq_eom; q_len <= nq_len;
      if (rel_vld) base <= AW'(rxq_pkg::ring_add(int'(base), int'(p_len), DEPTH));
      if (rel_vld || present) off <= '0;
      else if (rd_step)       off <= off + CW'(1);
      irq_rmr <= present && !np_eom;
      irq_rme <= present && np_eom;
      if (present) blk_len <= np_len;
      irq_ovf <= drop;
      if (drop)              stat_ovf <= 1'b1;
      else if (host_stat_rd) stat_ovf <= 1'b0;
    end
  end

  // R3
  irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_rmr, irq_rme, present && $past(present) && !$past(rel_vld) && !$past(seal)}));

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && p_vld && !host_rack && !seal && off >= p_len) |=> $stable(off));

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (stat_ovf && irq_ovf));

  // R8
  ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_stat_rd && !drop) |=> !stat_ovf);

  // R10
  idle_rack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rack && !p_vld && !seal) |=> (!irq_rmr && !irq_rme && $stable(base)));

endmodule

// File: rtl/rxq_ctl.sv
module rxq_ctl #(
  parameter int DW     = 8,
  parameter int DEPTH  = 64,
  parameter int THR_LO = 32,
  parameter int THR_HI = 48,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_thr48,
  input  logic          cfg_xp,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_eom,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic          host_rack,
  input  logic          host_stat_rd,
  output logic          irq_rmr,
  output logic          irq_rme,
  output logic          irq_ovf,
  output logic          stat_ovf,
  output logic [CW-1:0] blk_len
);

  // internal events between the admit stage and the block slots
  logic          wr_en, seal, seal_eom, drop;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] seal_len, rel_len;
  logic          slots_full, rel_vld;

  rxq_admit #(.DEPTH(DEPTH), .THR_LO(THR_LO), .THR_HI(THR_HI)) u_admit (
    .clk, .rst_n, .cfg_thr48, .cfg_xp, .rx_valid, .rx_eom,
    .slots_full, .rel_vld, .rel_len,
    .wr_en, .wr_addr, .seal, .seal_eom, .seal_len, .drop
  );

  rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk, .we(wr_en), .waddr(wr_addr), .wdata(rx_data),
    .raddr(rd_addr), .rdata(host_rdata)
  );

  rxq_slots #(.DEPTH(DEPTH)) u_slots (
    .clk, .rst_n, .seal, .seal_eom, .seal_len, .drop,
    .host_rd, .host_rack, .host_stat_rd,
    .slots_full, .rel_vld, .rel_len, .rd_addr,
    .irq_rmr, .irq_rme, .irq_ovf, .stat_ovf, .blk_len
  );

  // R9
  xp_no_eom_seal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_xp && seal) |-> (seal_len == CW'(cfg_thr48 ? THR_HI : THR_LO)));

endmodule

// File: tb/sim_rxq_ctl.sv
module sim_rxq_ctl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cfg_thr48, cfg_xp, rx_valid, rx_eom;
  logic host_rd, host_rack, host_stat_rd;
  logic [7:0] rx_data, host_rdata;
  logic irq_rmr, irq_rme, irq_ovf, stat_ovf;
  logic [6:0] blk_len;

  rxq_ctl u0 (.*);

  int errs = 0, checks = 0, rme_seen = 0;
  bit xp_phase = 0;
  logic [7:0] exp_q[$];

  always @(negedge clk) if (xp_phase && irq_rme) rme_seen++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: pushes expected stored bytes into the scoreboard queue
  task automatic drive(logic [7:0] d, bit eom, bit kept);
    @(negedge clk);
    rx_valid = 1; rx_data = d; rx_eom = eom;
    if (kept) exp_q.push_back(d);
  endtask

  task automatic idle();
    @(negedge clk);
    rx_valid = 0; rx_eom = 0;
    #1;
  endtask

  task automatic burst(int n, int start, bit eom_last, bit eom_all);
    for (int i = 0; i < n; i++)
      drive(8'(start + i), eom_all || (eom_last && i == n - 1), 1);
    idle();
  endtask

  // monitor side: pops the scoreboard and compares the read port
  task automatic read_blk(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      chk(req, host_rdata, exp_q.pop_front());
      host_rd = 1;
    end
    @(negedge clk); host_rd = 0; #1;
  endtask

  task automatic rack();
    @(negedge clk); host_rack = 1;
    @(negedge clk); host_rack = 0; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_thr48 = 0; cfg_xp = 0; rx_valid = 0; rx_eom = 0; rx_data = 0;
    host_rd = 0; host_rack = 0; host_stat_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk("R1 rmr", irq_rmr, 0); chk("R1 rme", irq_rme, 0);
    chk("R1 ovf", irq_ovf, 0); chk("R1 stat", stat_ovf, 0); chk("R1 len", blk_len, 0);

    // R10: acknowledge with nothing offered
    rack();
    chk("R10 rmr", irq_rmr, 0); chk("R10 rme", irq_rme, 0);

    // R2/R3 at 32 bytes, framed
    burst(31, 8'h10, 0, 0);
    chk("R2 short32", irq_rmr, 0);
    burst(1, 8'h2F, 0, 0);
    chk("R3 rmr32", irq_rmr, 1); chk("R3 len32", blk_len, 32); chk("R3 rme", irq_rme, 0);
    @(negedge clk); #1;
    chk("R3 pulse", irq_rmr, 0);
    read_blk(32, "R5 order");
    rack();
    chk("R6 none waiting", irq_rmr | irq_rme, 0);

    // R4/R6: two short messages, second one waits
    burst(3, 8'h40, 1, 0);
    chk("R4 rme", irq_rme, 1); chk("R4 len", blk_len, 3);
    burst(4, 8'h50, 1, 0);
    chk("R6 waiting silent", irq_rme, 0);
    read_blk(3, "R4 data");
    rack();
    chk("R6 next rme", irq_rme, 1); chk("R6 next len", blk_len, 4);
    read_blk(4, "R4 data2");
    rack();

    // R7/R5/R6/R8: late acknowledge at 32
    burst(32, 8'h60, 0, 0);
    chk("R3 rmr", irq_rmr, 1);
    burst(32, 8'h80, 0, 0);
    chk("R6 second waits", irq_rmr, 0);
    drive(8'hAA, 0, 0); idle();
    chk("R7 irq_ovf", irq_ovf, 1); chk("R7 stat_ovf", stat_ovf, 1);
    @(negedge clk); #1;
    chk("R7 ovf pulse", irq_ovf, 0);
    read_blk(32, "R5 data");
    chk("R5 at end", host_rdata, exp_q[0]);
    @(negedge clk); host_rd = 1; @(negedge clk); host_rd = 0; #1;
    chk("R5 no advance", host_rdata, exp_q[0]);
    rack();
    chk("R6 waiting rmr", irq_rmr, 1);
    read_blk(32, "R7 no dropped byte");
    rack();
    chk("R8 sticky", stat_ovf, 1);
    @(negedge clk); host_stat_rd = 1; @(negedge clk); host_stat_rd = 0; #1;
    chk("R8 cleared", stat_ovf, 0);

    // R2/R7 at 48 bytes
    cfg_thr48 = 1;
    burst(47, 8'h00, 0, 0);
    chk("R2 short48", irq_rmr, 0);
    burst(1, 8'h2F, 0, 0);
    chk("R2 rmr48", irq_rmr, 1); chk("R2 len48", blk_len, 48);
    burst(16, 8'hC0, 0, 0);
    chk("R7 room left", irq_ovf, 0);
    drive(8'hEE, 0, 0); idle();
    chk("R7 full48", irq_ovf, 1);
    read_blk(48, "R2 data48");
    rack();
    chk("R6 partial silent", irq_rmr, 0);
    burst(32, 8'h20, 0, 0);
    chk("R2 rmr48b", irq_rmr, 1); chk("R2 len48b", blk_len, 48);
    read_blk(48, "R7 order48");
    rack();

    // R9: transparent streaming with end flags
    cfg_thr48 = 0; cfg_xp = 1; xp_phase = 1;
    for (int i = 0; i < 32; i++) drive(8'(8'h90 + i), (i % 5) == 4, 1);
    idle();
    chk("R9 rmr", irq_rmr, 1); chk("R9 len", blk_len, 32);
    read_blk(32, "R9 data");
    rack();
    burst(32, 8'hB0, 0, 1);
    chk("R9 rmr2", irq_rmr, 1);
    read_blk(32, "R9 data2");
    rack();
    xp_phase = 0;
    chk("R9 no rme", rme_seen, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule